// File: doc/BRIEF.md
# Multi-Channel Memory Mode Resolver

This block sits next to a memory controller that drives up to four channel slots. Software or boot logic presents a descriptor for each slot on parallel inputs: a present bit, the capacity in 64-byte granules, a speed grade code, a CAS latency code and a geometry code. The geometry code summarises chip count, side count and row/column size. A one-cycle `cfg_valid` strobe captures these descriptors. The block then resolves how many channels interleave, whether a dual pair runs ganged, and the common speed and CAS latency that every channel must use.

After configuration the block translates physical byte addresses. It returns the channel (or channels) that hold the address, the byte address local to that channel, and an out-of-range flag. Capacity that every installed module shares is striped across the channels, one 64-byte granule at a time. Capacity that only some modules have sits above that striped region and is reached one channel at a time. With three channels the modulo-3 split runs on a bit-serial divider, so those lookups take longer and raise `busy` while they run.

Top module: `mc_mode_resolver`

## Requirements
- R1: The mode is the number of interleaved channels minus one (0 single, 1 dual, 2 triple, 3 quad). It equals the count of present modules minus one when all present modules carry the same speed code, CAS code and geometry code. If any of these differ, the mode is 0.
- R2: `run_speed` is the smallest speed code among the present modules, with a higher code meaning a faster module.
- R3: `run_cas` is the largest CAS code among the present modules.
- R4: `mode`, `ganged`, `run_speed`, `run_cas` and `cfg_err` take their new values in the cycle after the clock edge that samples `cfg_valid` high. They keep those values while `cfg_valid` is low, whatever the descriptor inputs do.
- R5: When timing and geometry match, each channel gets a striped share equal to the smallest present capacity C. The striped region holds n·C granules. The remainder of each module is stacked above it in ascending slot order. Granule g in the stacked area maps to the first slot whose cumulative remainder exceeds g − n·C, at local granule C plus the position inside that slot's remainder. In mismatched mode C is 0, so the modules are simply concatenated in slot order.
- R6: Granule g (address bits above bit 5) in the striped region goes to the k-th present slot in ascending order, where k = g mod n. Its local granule is g / n, and address bits 5..0 pass through unchanged. `rsp_chan` carries one bit per slot, bit i for slot i, and has exactly one bit set.
- R7: A striped lookup with three channels raises `busy` from the accepting edge for 15 cycles. `rsp_valid` is high in the cycle `busy` falls. Requests offered while `busy` is high are dropped.
- R8: Every other lookup sets `rsp_valid` for exactly one cycle, right after the edge that accepts it, and leaves `busy` low.
- R9: `ganged` is 1 only if `gang_req` was high at configuration and exactly two present modules match in timing, geometry and capacity. In that case each lookup sets both slot bits of `rsp_chan` and the local byte address is the address shifted right by one. Otherwise `ganged` is 0.
- R10: With no present module, `cfg_err` is 1 and every lookup returns out of range.
- R11: Any address at or above the total installed capacity returns `rsp_oor` high with `rsp_chan` and `rsp_local` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Capture strobe for the descriptors |
| gang_req | input | 1 | Request ganged operation for a matched pair |
| mod_present | input | 4 | Module installed, one bit per slot |
| mod_cap | input | 4*CAP_W | Capacity in 64-byte granules, slot i at bits i*CAP_W |
| mod_speed | input | 4*SPD_W | Speed grade code per slot |
| mod_cas | input | 4*CL_W | CAS latency code per slot |
| mod_geom | input | 4*GEO_W | Chip, side and row/column geometry code per slot |
| mode | output | 2 | Interleaved channel count minus one |
| ganged | output | 1 | Dual pair runs as one wide channel |
| run_speed | output | SPD_W | Common speed code |
| run_cas | output | CL_W | Common CAS latency code |
| cfg_err | output | 1 | No module present |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Physical byte address |
| busy | output | 1 | Three-way division in progress |
| rsp_valid | output | 1 | Lookup result valid, one cycle |
| rsp_chan | output | 4 | Target slot mask |
| rsp_local | output | ADDR_W | Channel-local byte address |
| rsp_oor | output | 1 | Address beyond installed capacity |

## Verification
A wrong latched configuration shows on the mode, speed and CAS outputs in the first cycle after the strobe, and on every later lookup's slot mask. A miscounted divider or a wrong striping share shows in the first lookup that targets the affected granule, as a wrong slot bit or local address, or as `rsp_valid` arriving in the wrong cycle. A divider that keeps running shows as `busy` staying high. The bench compares every one of these against its own model in every cycle, so a fault is reported in the cycle it first reaches a port.

// File: rtl/mc_mode_resolver.sv
module mc_mode_resolver #(
  parameter int ADDR_W = 20,
  parameter int SPD_W  = 4,
  parameter int CL_W   = 5,
  parameter int GEO_W  = 4,
  localparam int CAP_W = ADDR_W - 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  input  logic                gang_req,
  input  logic [3:0]          mod_present,
  input  logic [4*CAP_W-1:0]  mod_cap,
  input  logic [4*SPD_W-1:0]  mod_speed,
  input  logic [4*CL_W-1:0]   mod_cas,
  input  logic [4*GEO_W-1:0]  mod_geom,
  output logic [1:0]          mode,
  output logic                ganged,
  output logic [SPD_W-1:0]    run_speed,
  output logic [CL_W-1:0]     run_cas,
  output logic                cfg_err,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                busy,
  output logic                rsp_valid,
  output logic [3:0]          rsp_chan,
  output logic [ADDR_W-1:0]   rsp_local,
  output logic                rsp_oor
);
  localparam int WW    = CAP_W + 2;
  localparam int CNT_W = $clog2(CAP_W + 1);

  function automatic logic [1:0] slot_of(input logic [3:0] p, input logic [1:0] k);
    logic [2:0] c;
    logic [1:0] s;
    logic       f;
    c = '0; s = '0; f = 1'b0;
    for (int i = 0; i < 4; i++)
      if (p[i]) begin
        if (!f && c == {1'b0, k}) begin s = 2'(i); f = 1'b1; end
        c = c + 3'd1;
      end
    return s;
  endfunction

  // descriptor resolution
  logic [2:0]       n_c;
  logic             match;
  logic [SPD_W-1:0] min_spd, r_spd;
  logic [CL_W-1:0]  max_cl, r_cl;
  logic [GEO_W-1:0] r_geo;
  logic [CAP_W-1:0] min_cap, max_cap;

  always_comb begin
    n_c = '0; match = 1'b1; min_spd = '1; max_cl = '0;
    min_cap = '1; max_cap = '0; r_spd = '0; r_cl = '0; r_geo = '0;
    for (int i = 0; i < 4; i++)
      if (mod_present[i]) begin
        if (n_c == 3'd0) begin
          r_spd = mod_speed[i*SPD_W +: SPD_W];
          r_cl  = mod_cas[i*CL_W +: CL_W];
          r_geo = mod_geom[i*GEO_W +: GEO_W];
        end else if (mod_speed[i*SPD_W +: SPD_W] != r_spd || mod_cas[i*CL_W +: CL_W] != r_cl ||
                     mod_geom[i*GEO_W +: GEO_W] != r_geo)
          match = 1'b0;
        n_c = n_c + 3'd1;
        if (mod_speed[i*SPD_W +: SPD_W] < min_spd) min_spd = mod_speed[i*SPD_W +: SPD_W];
        if (mod_cas[i*CL_W +: CL_W] > max_cl) max_cl = mod_cas[i*CL_W +: CL_W];
        if (mod_cap[i*CAP_W +: CAP_W] < min_cap) min_cap = mod_cap[i*CAP_W +: CAP_W];
        if (mod_cap[i*CAP_W +: CAP_W] > max_cap) max_cap = mod_cap[i*CAP_W +: CAP_W];
      end
  end

  logic [3:0]       pres_q;
  logic [CAP_W-1:0] cap_q [4];
  logic [2:0]       nch_q;
  logic [CAP_W-1:0] ilv_q;
  logic [WW-1:0]    ilv_tot;
  assign ilv_tot = {2'b00, ilv_q} * WW'(nch_q);

  // address translation
  logic [CAP_W-1:0] g;
  logic [5:0]       off;
  logic [WW-1:0]    wide, r, acc, lo, t;
  logic [3:0]       d_mask;
  logic [CAP_W-1:0] d_locg;
  logic [ADDR_W-1:0] d_loc;
  logic             d_oor, d_div, found;
  assign g    = req_addr[ADDR_W-1:6];
  assign off  = req_addr[5:0];
  assign wide = {2'b00, g};

  always_comb begin
    d_mask = '0; d_locg = '0; d_loc = '0; d_oor = 1'b0; d_div = 1'b0;
    r = wide - ilv_tot; acc = '0; lo = '0; t = '0; found = 1'b0;
    if (cfg_err) d_oor = 1'b1;
    else if (ganged) begin
      if (wide >= ilv_tot) d_oor = 1'b1;
      else begin d_mask = pres_q; d_loc = req_addr >> 1; end
    end else if (wide < ilv_tot) begin
      case (nch_q)
        3'd3: d_div = 1'b1;
        3'd2: begin d_mask = 4'b1 << slot_of(pres_q, {1'b0, g[0]}); d_locg = g >> 1; end
        3'd4: begin d_mask = 4'b1 << slot_of(pres_q, g[1:0]); d_locg = g >> 2; end
        default: begin d_mask = 4'b1 << slot_of(pres_q, 2'd0); d_locg = g; end
      endcase
      d_loc = {d_locg, off};
    end else begin
      for (int i = 0; i < 4; i++)
        if (pres_q[i] && !found) begin
          lo = {2'b00, cap_q[i]} - {2'b00, ilv_q};
          if (r < acc + lo) begin
            found = 1'b1; d_mask = 4'b1 << i;
            t = {2'b00, ilv_q} + r - acc;
            d_locg = t[CAP_W-1:0];
          end
          acc = acc + lo;
        end
      if (found) d_loc = {d_locg, off};
      else d_oor = 1'b1;
    end
  end

  // bit-serial divide by three
  logic [CAP_W-1:0] quo_q;
  logic [1:0]       rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [5:0]       off_q;
  logic [2:0]       tri_t;
  logic             tri_ge;
  logic [2:0]       tri_r;
  assign tri_t  = {rem_q, quo_q[CAP_W-1]};
  assign tri_ge = tri_t >= 3'd3;
  assign tri_r  = tri_ge ? tri_t - 3'd3 : tri_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q <= '0; nch_q <= 3'd1; ilv_q <= '0;
      for (int i = 0; i < 4; i++) cap_q[i] <= '0;
      mode <= '0; ganged <= 1'b0; run_speed <= '0; run_cas <= '0; cfg_err <= 1'b0;
      busy <= 1'b0; rsp_valid <= 1'b0; rsp_chan <= '0; rsp_local <= '0; rsp_oor <= 1'b0;
      quo_q <= '0; rem_q <= '0; cnt_q <= '0; off_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_valid) begin
        pres_q <= mod_present;
        for (int i = 0; i < 4; i++) cap_q[i] <= mod_cap[i*CAP_W +: CAP_W];
        cfg_err   <= n_c == 3'd0;
        run_speed <= (n_c == 3'd0) ? '0 : min_spd;
        run_cas   <= max_cl;
        mode      <= (match && n_c != 3'd0) ? 2'(n_c - 3'd1) : 2'd0;
        nch_q     <= (match && n_c != 3'd0) ? n_c : 3'd1;
        ilv_q     <= (match && n_c != 3'd0) ? min_cap : '0;
        ganged    <= gang_req && match && n_c == 3'd2 && min_cap == max_cap;
      end
      if (busy) begin
        if (cnt_q != '0) begin
          quo_q <= {quo_q[CAP_W-2:0], tri_ge};
          rem_q <= tri_r[1:0];
          cnt_q <= cnt_q - 1'b1;
        end else begin
          busy <= 1'b0; rsp_valid <= 1'b1; rsp_oor <= 1'b0;
          rsp_chan  <= 4'b1 << slot_of(pres_q, rem_q);
          rsp_local <= {quo_q, off_q};
        end
      end else if (req_valid) begin
        if (d_div) begin
          busy <= 1'b1; quo_q <= g; rem_q <= '0; cnt_q <= CNT_W'(CAP_W); off_q <= off;
        end else begin
          rsp_valid <= 1'b1; rsp_chan <= d_mask; rsp_local <= d_loc; rsp_oor <= d_oor;
        end
      end
    end
  end

  // R6
  onehot_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_oor && !ganged |-> $countones(rsp_chan) == 1);
  // R6
  present_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_chan & ~pres_q) == 4'b0);
  // R11
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_oor |-> rsp_chan == 4'b0);
  // R7
  div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_valid) |-> $stable(mode) && $stable(run_speed) && $stable(run_cas) && $stable(ganged));
  // R10
  err_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && cfg_err |-> rsp_oor);
endmodule

// File: tb/mc_mode_resolver_test.sv
module mc_mode_resolver_test;
  localparam int ADDR_W = 20, SPD_W = 4, CL_W = 5, GEO_W = 4, CAP_W = ADDR_W - 6;

  logic clk = 0, rst_n = 0, cfg_valid = 0, gang_req = 0, req_valid = 0;
  logic [3:0] mod_present = 0;
  logic [4*CAP_W-1:0] mod_cap = 0;
  logic [4*SPD_W-1:0] mod_speed = 0;
  logic [4*CL_W-1:0] mod_cas = 0;
  logic [4*GEO_W-1:0] mod_geom = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [1:0] mode; logic ganged, cfg_err, busy, rsp_valid, rsp_oor;
  logic [SPD_W-1:0] run_speed; logic [CL_W-1:0] run_cas;
  logic [3:0] rsp_chan; logic [ADDR_W-1:0] rsp_local;

  mc_mode_resolver #(.ADDR_W(ADDR_W), .SPD_W(SPD_W), .CL_W(CL_W), .GEO_W(GEO_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .gang_req(gang_req),
    .mod_present(mod_present), .mod_cap(mod_cap), .mod_speed(mod_speed), .mod_cas(mod_cas),
    .mod_geom(mod_geom), .mode(mode), .ganged(ganged), .run_speed(run_speed), .run_cas(run_cas),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_local(rsp_local), .rsp_oor(rsp_oor));

  always #2 clk = ~clk;

  int total = 0, fails = 0;
  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model state
  int m_pres, m_cap[4], m_nch, m_ilv, m_mode, m_gang, m_spd, m_cas, m_err;
  int m_cnt, m_busy, m_rv, m_chan, m_loc, m_oor;
  int p_chan, p_loc, p_oor;
  string m_tag = "R8", p_tag = "R7";

  function automatic int kth(int p, int k);
    int c = 0;
    for (int i = 0; i < 4; i++)
      if ((p >> i) & 1) begin
        if (c == k) return i;
        c++;
      end
    return 0;
  endfunction

  task automatic model_map(input int a, output int ch, output int loc, output int oor,
                           output int dv, output string tag);
    int gg = a / 64, of = a % 64, rr, acc = 0, lo;
    ch = 0; loc = 0; oor = 0; dv = 0; tag = "R6";
    if (m_err != 0) begin oor = 1; tag = "R10"; end
    else if (m_gang != 0) begin
      tag = "R9";
      if (gg >= 2 * m_ilv) oor = 1;
      else begin ch = m_pres; loc = a / 2; end
    end else if (gg < m_nch * m_ilv) begin
      ch = 1 << kth(m_pres, gg % m_nch);
      loc = (gg / m_nch) * 64 + of;
      dv = (m_nch == 3) ? 1 : 0;
      if (dv != 0) tag = "R7";
    end else begin
      tag = "R5";
      rr = gg - m_nch * m_ilv;
      oor = 1;
      for (int i = 0; i < 4; i++)
        if (((m_pres >> i) & 1) != 0 && oor != 0) begin
          lo = m_cap[i] - m_ilv;
          if (rr < acc + lo) begin oor = 0; ch = 1 << i; loc = (m_ilv + rr - acc) * 64 + of; end
          acc += lo;
        end
      if (oor != 0) tag = "R11";
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pres = 0; m_nch = 1; m_ilv = 0; m_mode = 0; m_gang = 0; m_spd = 0; m_cas = 0;
      m_err = 0; m_cnt = 0; m_busy = 0; m_rv = 0;
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
    end else begin
      int ch, loc, oor, dv, n, mt, mins, maxc, minc, maxcp;
      string tg;
      m_rv = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_rv = 1; m_chan = p_chan; m_loc = p_loc; m_oor = p_oor; m_tag = p_tag;
        end
      end else if (req_valid) begin
        model_map(int'(req_addr), ch, loc, oor, dv, tg);
        if (dv != 0) begin
          m_busy = 1; m_cnt = CAP_W + 1; p_chan = ch; p_loc = loc; p_oor = oor; p_tag = tg;
        end else begin
          m_rv = 1; m_chan = ch; m_loc = loc; m_oor = oor; m_tag = tg;
        end
      end
      if (cfg_valid) begin
        n = 0; mt = 1; mins = 99; maxc = 0; minc = 1 << 30; maxcp = 0;
        for (int i = 0; i < 4; i++)
          if (mod_present[i]) begin
            if (mod_speed[i*SPD_W +: SPD_W] != mod_speed[kth(int'(mod_present), 0)*SPD_W +: SPD_W] ||
                mod_cas[i*CL_W +: CL_W] != mod_cas[kth(int'(mod_present), 0)*CL_W +: CL_W] ||
                mod_geom[i*GEO_W +: GEO_W] != mod_geom[kth(int'(mod_present), 0)*GEO_W +: GEO_W])
              mt = 0;
            n++;
            if (int'(mod_speed[i*SPD_W +: SPD_W]) < mins) mins = int'(mod_speed[i*SPD_W +: SPD_W]);
            if (int'(mod_cas[i*CL_W +: CL_W]) > maxc) maxc = int'(mod_cas[i*CL_W +: CL_W]);
            if (int'(mod_cap[i*CAP_W +: CAP_W]) < minc) minc = int'(mod_cap[i*CAP_W +: CAP_W]);
            if (int'(mod_cap[i*CAP_W +: CAP_W]) > maxcp) maxcp = int'(mod_cap[i*CAP_W +: CAP_W]);
          end
        m_pres = int'(mod_present);
        for (int i = 0; i < 4; i++) m_cap[i] = int'(mod_cap[i*CAP_W +: CAP_W]);
        m_err = (n == 0) ? 1 : 0;
        m_spd = (n == 0) ? 0 : mins;
        m_cas = maxc;
        m_mode = (mt != 0 && n > 0) ? n - 1 : 0;
        m_nch = (mt != 0 && n > 0) ? n : 1;
        m_ilv = (mt != 0 && n > 0) ? minc : 0;
        m_gang = (gang_req && mt != 0 && n == 2 && minc == maxcp) ? 1 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 R4 mode", mode, m_mode);
      chk("R2 R4 run_speed", run_speed, m_spd);
      chk("R3 R4 run_cas", run_cas, m_cas);
      chk("R9 ganged", ganged, m_gang);
      chk("R10 cfg_err", cfg_err, m_err);
      chk("R7 busy", busy, m_busy);
      chk("R8 rsp_valid", rsp_valid, m_rv);
      if (rsp_valid && m_rv != 0) begin
        chk({m_tag, " rsp_chan"}, rsp_chan, m_chan);
        chk({m_tag, " rsp_local"}, rsp_local, m_loc);
        chk({m_tag, " rsp_oor"}, rsp_oor, m_oor);
      end
    end
  end

  int t_cap[4], t_spd[4], t_cas[4], t_geo[4];
  task automatic desc_default(input int cap);
    for (int i = 0; i < 4; i++) begin t_cap[i] = cap; t_spd[i] = 8; t_cas[i] = 11; t_geo[i] = 3; end
  endtask

  task automatic apply(input logic [3:0] p, input logic gq);
    @(negedge clk);
    mod_present = p; gang_req = gq; cfg_valid = 1;
    for (int i = 0; i < 4; i++) begin
      mod_cap[i*CAP_W +: CAP_W] = CAP_W'(t_cap[i]);
      mod_speed[i*SPD_W +: SPD_W] = SPD_W'(t_spd[i]);
      mod_cas[i*CL_W +: CL_W] = CL_W'(t_cas[i]);
      mod_geom[i*GEO_W +: GEO_W] = GEO_W'(t_geo[i]);
    end
    @(negedge clk);
    cfg_valid = 0; gang_req = ~gq;
    mod_present = ~p; mod_speed = ~mod_speed; mod_cas = ~mod_cas; mod_cap = ~mod_cap;
    repeat (2) @(negedge clk);
  endtask

  task automatic look(input int gg, input int of);
    req_addr = ADDR_W'(gg * 64 + of); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state and no modules
    look(0, 0);
    // R1 R6 quad, equal capacities
    desc_default(1024);
    apply(4'b1111, 0);
    for (int k = 0; k < 6; k++) look(k, k * 7);
    look(4095, 63); look(4096, 0);            // R11
    // R5 flex split
    t_cap[0] = 100; t_cap[1] = 200; t_cap[2] = 100; t_cap[3] = 300;
    apply(4'b1111, 0);
    look(399, 5); look(400, 1); look(499, 2); look(500, 3); look(699, 4); look(700, 0);
    // R7 triple on slots 0,2,3 with a dropped request while busy
    desc_default(50);
    apply(4'b1101, 0);
    look(0, 0); look(1, 9); look(2, 10); look(5, 11); look(149, 63); look(150, 0);
    req_addr = ADDR_W'(77 * 64); req_valid = 1;
    @(negedge clk);
    req_addr = ADDR_W'(4 * 64); @(negedge clk);
    req_valid = 0;
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
    // R9 ganged pair
    desc_default(64);
    apply(4'b0110, 1);
    look(0, 1); look(127, 63); look(128, 0);
    // R9 unequal pair stays unganged
    t_cap[1] = 40; t_cap[2] = 64;
    apply(4'b0110, 1);
    look(79, 0); look(80, 0); look(103, 5); look(104, 0);
    // R1 R2 R3 mismatch falls back to concatenation
    desc_default(30);
    t_spd[0] = 12; t_spd[3] = 6; t_cas[0] = 9; t_cas[3] = 15;
    apply(4'b1001, 0);
    look(29, 1); look(30, 2); look(59, 3); look(60, 0);
    // R1 geometry mismatch, single present module
    desc_default(20);
    t_geo[1] = 7;
    apply(4'b0011, 0);
    look(21, 0);
    apply(4'b0100, 0);
    look(19, 8); look(20, 0);
    // R10 no modules
    apply(4'b0000, 0);
    look(3, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule